// File: doc/BRIEF.md
# HDLC Serial Receive Deframer

This block turns a bit-serial HDLC line into octets for an 8-bit backend. It samples one line bit per receive clock while the receive enable is high. It finds the delimiting flags and removes the zeros that the transmitter stuffed after runs of ones. It recognises aborts and the all-ones idle line, and packs the surviving bits into bytes, least significant bit first. The backend runs on the same receive clock.

Each recovered byte is offered with a ready indication and stays on the data bus until the backend returns a read strobe. A frame window output stays high from the first data bit of a frame until one cycle after its closing flag or abort. During that window the error and abort outputs report the frame's status. When the frame check is enabled, the two octets in front of the closing flag are taken as a CRC-16 check sequence. They are verified and never handed to the backend.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The octet 0x7E (0 1 1 1 1 1 1 0 on the line) delimits frames. Bits between an opening and a closing flag are frame content, and the flag bits themselves are never delivered.
- R2: A 0 received right after five consecutive 1s is discarded. The bits on either side of it join up in the data stream.
- R3: Content bits are packed least significant bit first. Octet k of the frame (k = 0, 1, ...) is delivered as the k-th byte on `rd_data`.
- R4: Seven consecutive 1s inside a frame abort it. `frame_aborted` is high in the last cycle of `frame_valid` for that frame, and `frame_aborted` is never high while `frame_valid` is low.
- R5: An all-ones line, and flags followed by all ones, never raise `frame_valid` or `byte_ready`.
- R6: `byte_ready` rises only when a byte is delivered. It then holds, with `rd_data` unchanged, until a cycle with `byte_read` high, after which it falls unless a new byte arrives in that same cycle.
- R7: A byte left unread through the 7 receive clocks after `byte_ready` rises sets `frame_err`. A read in any of those 7 clocks avoids the error. The error stays set until the frame window closes.
- R8: A frame whose content is not a whole number of octets ends with `frame_err` high.
- R9: With `FCS_EN`=1, the last 16 content bits are checked with CRC-16 (x^16+x^12+x^5+1, bit-reflected, preset 0xFFFF, good residue 0xF0B8), and a mismatch ends the frame with `frame_err` high. These two octets are not delivered.
- R10: Clocks with `rx_en` low do not advance reception. The line value during those clocks has no effect on the delivered bytes or the frame status.
- R11: `rst_n` low asynchronously clears `byte_ready`, `frame_valid`, `frame_err` and `frame_aborted`.
- R12: `frame_err` is never high while `frame_valid` is low. Each completed frame drops `frame_valid` exactly once.
- R13: Back-to-back flags, or a flag with no content before it, open a new frame without any frame window or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; also clocks the backend handshake |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable, active high |
| rx_bit | input | 1 | Serial line data |
| byte_read | input | 1 | Backend read strobe for the offered byte |
| rd_data | output | 8 | Offered data byte |
| byte_ready | output | 1 | A byte is waiting on `rd_data` |
| frame_valid | output | 1 | Frame window; high across all bytes of a frame |
| frame_err | output | 1 | Late read, octet misalignment or check-sequence failure |
| frame_aborted | output | 1 | Current frame was ended by an abort |

## Verification
On every cycle, the assertions check the backend handshake: ready is held until read, the data is stable while ready is high, and ready rises only on a delivery. They also count the read window and require an error when it lapses, and they keep error and abort inside the frame window. Flag and abort recognition, destuffing, bit order, the CRC verdict and the enable gating depend on whole line sequences. The bench shows those through its scenarios: it encodes frames with stuffing and a computed check sequence, and compares the delivered bytes and the status of each frame.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int OCTET_W    = 8;
    localparam int FLAG_W     = 8;
    localparam int STUFF_RUN  = 5;
    localparam int CRC_W      = 16;
    localparam int FCS_OCTETS = CRC_W / OCTET_W;
    localparam int RUN_W      = $clog2(FLAG_W);

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_RESIDUE   = 16'hF0B8;

    // one event word per receive clock from the line stage
    typedef struct packed {
        logic bit_v;   // a content bit leaves the delay line
        logic bit_d;   // its value
        logic flag;    // closing bit of a flag seen now
        logic abort;   // seventh consecutive one seen now
    } line_ev_t;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_OPEN,
        ST_BODY
    } frm_state_e;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic [CRC_W-1:0] n;
        n = c >> 1;
        if (c[0] ^ b)
            n = n ^ CRC_POLY_REFL;
        return n;
    endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     bit_in,
    output line_ev_t ev
);

    localparam logic [RUN_W-1:0] RUN_MAX   = RUN_W'(FLAG_W - 1);
    localparam logic [RUN_W-1:0] RUN_STUFF = RUN_W'(STUFF_RUN);
    localparam logic [RUN_W-1:0] RUN_FLAG  = RUN_W'(STUFF_RUN + 1);

    logic [RUN_W-1:0]  run_q;
    logic [FLAG_W-1:0] dly_d_q;
    logic [FLAG_W-1:0] dly_k_q;

    logic is_stuff, is_flag, is_abort, keep_new;
    logic [RUN_W-1:0] run_n;

    always_comb begin
        is_stuff = !bit_in && (run_q == RUN_STUFF);
        is_flag  = !bit_in && (run_q == RUN_FLAG);
        is_abort =  bit_in && (run_q == RUN_FLAG);
        // a sixth or later one can never be content
        keep_new = !is_stuff && !(bit_in && (run_q >= RUN_STUFF));
        if (!bit_in)
            run_n = '0;
        else if (run_q == RUN_MAX)
            run_n = RUN_MAX;
        else
            run_n = run_q + 1'b1;
    end

    always_comb begin
        ev.bit_v = en && dly_k_q[FLAG_W-1];
        ev.bit_d = dly_d_q[FLAG_W-1];
        ev.flag  = en && is_flag;
        ev.abort = en && is_abort;
    end

    // the delay line lets the bits of a flag be cancelled before they leave
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            dly_d_q <= '0;
            dly_k_q <= '0;
        end else if (en) begin
            run_q   <= run_n;
            dly_d_q <= {dly_d_q[FLAG_W-2:0], bit_in};
            if (is_flag || is_abort)
                dly_k_q <= '0;
            else
                dly_k_q <= {dly_k_q[FLAG_W-2:0], keep_new};
        end
    end

endmodule

// File: rtl/hdlc_rx_octet.sv
module hdlc_rx_octet
    import hdlc_rx_pkg::*;
#(
    parameter bit FCS_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  line_ev_t           ev,
    input  logic               late,
    output logic               dlv_v,
    output logic [OCTET_W-1:0] dlv_data,
    output logic               frame_valid,
    output logic               frame_err,
    output logic               frame_aborted
);

    localparam int CNT_W = $clog2(OCTET_W);

    frm_state_e         st_q;
    logic [OCTET_W-1:0] sr_q, sr_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n;
    logic [CRC_W-1:0]   crc_q, crc_n;
    logic               end_q, err_q, abt_q;
    logic               take, in_body, active, oct_done, misalign, crc_bad;

    always_comb begin
        in_body  = (st_q == ST_BODY);
        take     = ev.bit_v && (st_q != ST_HUNT) && !ev.abort;
        sr_n     = take ? {ev.bit_d, sr_q[OCTET_W-1:1]} : sr_q;
        cnt_n    = take ? cnt_q + 1'b1 : cnt_q;
        crc_n    = take ? crc_step(crc_q, ev.bit_d) : crc_q;
        oct_done = take && (cnt_q == CNT_W'(OCTET_W - 1));
        active   = in_body || take;
        misalign = (cnt_n != '0);
        crc_bad  = FCS_EN && (crc_n != CRC_RESIDUE);
    end

    generate
        if (FCS_EN) begin : g_fcs_hold
            localparam int HC_W = $clog2(FCS_OCTETS + 1);
            logic [OCTET_W-1:0] hold_q [FCS_OCTETS];
            logic [HC_W-1:0]    hcnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hcnt_q <= '0;
                    for (int i = 0; i < FCS_OCTETS; i++)
                        hold_q[i] <= '0;
                end else if (ev.flag || ev.abort) begin
                    hcnt_q <= '0;
                end else if (oct_done) begin
                    hold_q[0] <= sr_n;
                    for (int i = 1; i < FCS_OCTETS; i++)
                        hold_q[i] <= hold_q[i-1];
                    if (hcnt_q != HC_W'(FCS_OCTETS))
                        hcnt_q <= hcnt_q + 1'b1;
                end
            end

            assign dlv_v    = oct_done && (hcnt_q == HC_W'(FCS_OCTETS));
            assign dlv_data = hold_q[FCS_OCTETS-1];
        end else begin : g_direct
            assign dlv_v    = oct_done;
            assign dlv_data = sr_n;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            sr_q  <= '0;
            cnt_q <= '0;
            crc_q <= CRC_PRESET;
            end_q <= 1'b0;
            err_q <= 1'b0;
            abt_q <= 1'b0;
        end else begin
            end_q <= 1'b0;
            if (end_q) begin
                err_q <= 1'b0;
                abt_q <= 1'b0;
            end
            if (late && in_body)
                err_q <= 1'b1;

            if (ev.abort) begin
                st_q <= ST_HUNT;
                if (in_body) begin
                    abt_q <= 1'b1;
                    end_q <= 1'b1;
                end
            end else if (ev.flag) begin
                st_q  <= ST_OPEN;
                sr_q  <= '0;
                cnt_q <= '0;
                crc_q <= CRC_PRESET;
                if (active) begin
                    end_q <= 1'b1;
                    err_q <= err_q | (late && in_body) | misalign | crc_bad;
                end
            end else if (take) begin
                st_q  <= ST_BODY;
                sr_q  <= sr_n;
                cnt_q <= cnt_n;
                crc_q <= crc_n;
            end
        end
    end

    assign frame_valid   = in_body || end_q;
    assign frame_err     = err_q;
    assign frame_aborted = abt_q;

endmodule

// File: rtl/hdlc_rx_handoff.sv
module hdlc_rx_handoff
    import hdlc_rx_pkg::*;
#(
    parameter int WINDOW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dlv_v,
    input  logic [OCTET_W-1:0] dlv_data,
    input  logic               byte_read,
    output logic [OCTET_W-1:0] rd_data,
    output logic               byte_ready,
    output logic               late
);

    localparam int WT_W = $clog2(WINDOW + 1);
    localparam logic [WT_W-1:0] WT_LAST = WT_W'(WINDOW - 1);
    localparam logic [WT_W-1:0] WT_SAT  = WT_W'(WINDOW);

    logic [OCTET_W-1:0] data_q;
    logic               rdy_q;
    logic [WT_W-1:0]    wait_q;

    // window lapse, or a new byte overwriting an unread one
    assign late = rdy_q && !byte_read && (dlv_v || (wait_q == WT_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
            wait_q <= '0;
        end else if (dlv_v) begin
            data_q <= dlv_data;
            rdy_q  <= 1'b1;
            wait_q <= '0;
        end else if (rdy_q) begin
            if (byte_read)
                rdy_q <= 1'b0;
            else if (wait_q != WT_SAT)
                wait_q <= wait_q + 1'b1;
        end
    end

    assign rd_data    = data_q;
    assign byte_ready = rdy_q;

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter bit FCS_EN      = 1'b1,
    parameter int READ_WINDOW = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       rx_bit,
    input  logic       byte_read,
    output logic [7:0] rd_data,
    output logic       byte_ready,
    output logic       frame_valid,
    output logic       frame_err,
    output logic       frame_aborted
);

    line_ev_t           ev;
    logic               dlv_v;
    logic [OCTET_W-1:0] dlv_data;
    logic               late;

    hdlc_rx_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (rx_en),
        .bit_in (rx_bit),
        .ev     (ev)
    );

    hdlc_rx_octet #(.FCS_EN(FCS_EN)) u_octet (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (ev),
        .late          (late),
        .dlv_v         (dlv_v),
        .dlv_data      (dlv_data),
        .frame_valid   (frame_valid),
        .frame_err     (frame_err),
        .frame_aborted (frame_aborted)
    );

    hdlc_rx_handoff #(.WINDOW(READ_WINDOW)) u_handoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .dlv_v      (dlv_v),
        .dlv_data   (dlv_data),
        .byte_read  (byte_read),
        .rd_data    (rd_data),
        .byte_ready (byte_ready),
        .late       (late)
    );

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
    parameter int WINDOW = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_read,
    input logic       byte_ready,
    input logic [7:0] rd_data,
    input logic       frame_valid,
    input logic       frame_err,
    input logic       frame_aborted,
    input logic       dlv_v
);

    int wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wcnt <= 0;
        else if (dlv_v)
            wcnt <= 0;
        else if (byte_ready && !byte_read && wcnt != WINDOW)
            wcnt <= wcnt + 1;
    end

    // R12: error only inside the frame window
    p_err_in_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> frame_valid);

    // R4: abort only inside the frame window
    p_abort_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_aborted |-> frame_valid);

    // R6: ready holds until read
    p_ready_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && !byte_read |=> byte_ready);

    // R6: a read with no new byte releases ready
    p_read_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && byte_read && !dlv_v |=> !byte_ready);

    // R6: offered data stays put
    p_data_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && !dlv_v |=> $stable(rd_data));

    // R6: ready rises only after a delivery
    p_ready_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_ready) |-> $past(dlv_v));

    // R7: window lapse inside a frame raises the error
    p_window_lapse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && !byte_read && (wcnt == WINDOW - 1) && frame_valid
        |=> frame_err || !frame_valid);

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.WINDOW(READ_WINDOW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_read     (byte_read),
    .byte_ready    (byte_ready),
    .rd_data       (rd_data),
    .frame_valid   (frame_valid),
    .frame_err     (frame_err),
    .frame_aborted (frame_aborted),
    .dlv_v         (dlv_v)
);

// File: tb/test_hdlc_rx_deframer.sv
module test_hdlc_rx_deframer;

    localparam int CLK_PERIOD = 10;

    // {count[2:0], bytes[31:0] (byte 0 lowest), kind[1:0]}
    // kind: 0 good, 1 corrupted check sequence, 2 misaligned, 3 aborted
    localparam logic [36:0] VEC [6] = '{
        {3'd4, 32'h4433_2211, 2'd0},
        {3'd4, 32'h3EF8_7EFF, 2'd0},
        {3'd1, 32'h0000_00A5, 2'd0},
        {3'd3, 32'h00C3_5A01, 2'd1},
        {3'd2, 32'h0000_F00F, 2'd2},
        {3'd2, 32'h0000_1234, 2'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       byte_read = 1'b0;
    logic [7:0] rd_data;
    logic       byte_ready, frame_valid, frame_err, frame_aborted;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_deframer i_hdlc_rx_deframer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .rx_bit        (rx_bit),
        .byte_read     (byte_read),
        .rd_data       (rd_data),
        .byte_ready    (byte_ready),
        .frame_valid   (frame_valid),
        .frame_err     (frame_err),
        .frame_aborted (frame_aborted)
    );

    int         checks = 0, fails = 0;
    int         ends, valid_cycles, ready_cycles, ngot;
    logic       last_err, last_abt, end_err, end_abt, prev_valid = 1'b0;
    logic [7:0] got [64];
    int         rd_delay = 0, wcnt = 0, gap = 0, tx_ones = 0;
    logic       pending = 1'b0;
    logic [15:0] tx_crc;
    bit         done = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        ends = 0; valid_cycles = 0; ready_cycles = 0; ngot = 0;
        last_err = 1'b0; last_abt = 1'b0; end_err = 1'b0; end_abt = 1'b0;
    endtask

    task automatic tick(input logic b, input logic en);
        @(negedge clk);
        if (frame_valid) begin
            last_err = frame_err;
            last_abt = frame_aborted;
            valid_cycles++;
        end
        if (prev_valid && !frame_valid) begin
            ends++;
            end_err = last_err;
            end_abt = last_abt;
        end
        prev_valid = frame_valid;
        if (byte_ready) ready_cycles++;
        byte_read = 1'b0;
        if (byte_ready && !pending) begin
            pending = 1'b1;
            wcnt = 0;
        end
        if (pending) begin
            if (wcnt >= rd_delay) begin
                if (ngot < 64) got[ngot] = rd_data;
                ngot++;
                byte_read = 1'b1;
                pending = 1'b0;
            end else begin
                wcnt++;
            end
        end
        rx_bit = b;
        rx_en = en;
    endtask

    task automatic send_raw(input logic b);
        tick(b, 1'b1);
        tx_ones = b ? tx_ones + 1 : 0;
        for (int g = 0; g < gap; g++)
            tick(~b, 1'b0);
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
    endtask

    task automatic send_data_bit(input logic b);
        logic fb;
        fb = tx_crc[0] ^ b;
        tx_crc = tx_crc >> 1;
        if (fb) tx_crc = tx_crc ^ 16'h8408;
        send_raw(b);
        if (b && tx_ones == 5) send_raw(1'b0);
    endtask

    task automatic send_octet(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    task automatic send_frame(input int n, input logic [31:0] bytes, input int kind);
        logic [15:0] fcs;
        clear_mon();
        tx_crc = 16'hFFFF;
        send_flag();
        for (int i = 0; i < n; i++) send_octet(bytes[8*i +: 8]);
        if (kind == 3) begin
            for (int i = 0; i < 8; i++) send_raw(1'b1);
        end else begin
            fcs = ~tx_crc;
            if (kind == 1) fcs = fcs ^ 16'h0001;
            send_octet(fcs[7:0]);
            send_octet(fcs[15:8]);
            if (kind == 2)
                for (int i = 0; i < 3; i++) send_data_bit(1'b0);
        end
        send_flag();
        for (int i = 0; i < 16; i++) tick(1'b1, 1'b1);
    endtask

    task automatic check_bytes(input string tag, input int n, input logic [31:0] bytes);
        check({tag, " byte count"}, ngot, n);
        for (int i = 0; i < n && i < ngot; i++)
            check({tag, " byte value"}, int'(got[i]), int'(bytes[8*i +: 8]));
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_mon();
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);
        // R11: reset state
        check("R11 ready after reset", byte_ready, 0);
        check("R11 valid after reset", frame_valid, 0);
        check("R11 err after reset", frame_err, 0);
        check("R11 abort after reset", frame_aborted, 0);
        rst_n = 1'b1;

        // R5: idle line
        clear_mon();
        for (int i = 0; i < 40; i++) tick(1'b1, 1'b1);
        check("R5 idle valid cycles", valid_cycles, 0);
        check("R5 idle ready cycles", ready_cycles, 0);

        // table walk: R1 R2 R3 R4 R8 R9 R12
        for (int v = 0; v < 6; v++) begin
            int n;
            int kind;
            n = int'(VEC[v][36:34]);
            kind = int'(VEC[v][1:0]);
            send_frame(n, VEC[v][33:2], kind);
            check("R12 one window close per frame", ends, 1);
            check("R8 R9 frame error verdict", end_err, (kind == 1 || kind == 2) ? 1 : 0);
            check("R4 abort verdict", end_abt, (kind == 3) ? 1 : 0);
            if (kind <= 1)
                check_bytes("R1 R2 R3 R9 delivered", n, VEC[v][33:2]);
        end

        // R13: repeated flags then a frame
        clear_mon();
        send_flag(); send_flag(); send_flag();
        for (int i = 0; i < 12; i++) tick(1'b1, 1'b1);
        check("R13 flags only no window", valid_cycles, 0);
        check("R13 flags only no error", end_err, 0);
        send_flag(); send_flag();
        send_frame(2, 32'h0000_6C81, 0);
        check("R13 frame after flags err", end_err, 0);
        check_bytes("R13 frame after flags", 2, 32'h0000_6C81);

        // R10: enable gaps with opposite line value
        gap = 3;
        send_frame(3, 32'h00E7_1F80, 0);
        gap = 0;
        check("R10 gated frame err", end_err, 0);
        check("R10 gated frame closes", ends, 1);
        check_bytes("R10 gated frame", 3, 32'h00E7_1F80);

        // R7: read window boundary
        rd_delay = 6;
        send_frame(4, 32'h9988_7766, 0);
        check("R7 read at last allowed clock no error", end_err, 0);
        check_bytes("R7 late but in window", 4, 32'h9988_7766);
        rd_delay = 7;
        send_frame(4, 32'h9988_7766, 0);
        check("R7 read past window error", end_err, 1);
        rd_delay = 0;

        // R11: asynchronous reset in mid frame
        clear_mon();
        send_flag();
        send_octet(8'h5A);
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        check("R11 async reset clears window", frame_valid, 0);
        check("R11 async reset clears ready", byte_ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        prev_valid = 1'b0;
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule